// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the 32-bit program counter of a simple in-order core and picks its next value every clock. A decoder supplies a three-bit control class together with the raw instruction fields: a 16-bit branch displacement, a 26-bit jump field, two register values to compare, and a register-held jump target. From these the unit picks one of six outcomes: fall through to the next word, a conditional branch on equality or on inequality, a region-local jump, a jump that also records a return address, or a jump through a register.

The branch target is taken relative to the address of the following instruction. The displacement is sign-extended and scaled to words. A region-local jump keeps the top four bits of the current PC and replaces the rest with the 26-bit field scaled to words. The link outputs tell the register file which register receives the return address and what to write there. A stall input freezes the PC. A redirect whose target is not word aligned raises a fault flag and leaves the PC where it was. All pins are plain level signals. There is no handshake, because the PC is consumed every cycle and back-pressure arrives only through the stall pin.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a clock edge the PC loads `RESET_VEC` (default 0), and `pc_o` shows that value from the following cycle.
- R2: Class code 0, and the unused codes 6 and 7, advance the PC by 4.
- R3: Class code 1 (branch on equal) with `cmp_a_i == cmp_b_i` loads PC + 4 + (sign-extended `br_off_i` × 4), all modulo 2^32. With unequal operands it advances by 4.
- R4: Class code 2 (branch on not-equal) takes the same target when the operands differ, and advances by 4 when they are equal.
- R5: Class code 3 (region jump) loads {PC[31:28], `jfield_i`, 2'b00}.
- R6: Class code 4 (jump with link) loads the same target as R5. In the same cycle it raises `link_we_o`, drives `link_addr_o` = PC + 4 and drives `link_idx_o` = 31.
- R7: Class code 5 (register jump) loads `jreg_i`.
- R8: When the selected redirect target has either of its two low bits set, `fault_o` is high in that cycle, the PC keeps its value and `link_we_o` stays low.
- R9: While `stall_i` is high the PC keeps its value whatever the class, and both `fault_o` and `link_we_o` stay low. A stall outranks every redirect.
- R10: A negative displacement moves the PC backwards, and the target wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the PC this cycle |
| cls_i | input | 3 | Control class code |
| br_off_i | input | 16 | Signed branch displacement in words |
| jfield_i | input | 26 | Jump word-address field |
| cmp_a_i | input | 32 | First compared register value |
| cmp_b_i | input | 32 | Second compared register value |
| jreg_i | input | 32 | Register-held jump target |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Write the return address this cycle |
| link_addr_o | output | 32 | Return address (PC + 4) |
| link_idx_o | output | 5 | Register index that receives the return address |
| fault_o | output | 1 | Selected redirect target is misaligned |

## Verification
`fault_o`, `link_we_o`, `link_addr_o` and `link_idx_o` are combinational from the current PC and the inputs, so they are due in the same cycle as the stimulus. The new PC is due one clock after that, since it passes through a single register. The bench drives inputs on the falling edge and samples the combinational results just after that edge, before the next rising edge. It then samples `pc_o` just after the rising edge and compares it with a next-PC value that it computes arithmetically from its own model of the PC. The sweep covers every class code, with and without stall, with equal and unequal operands, with extreme displacements, and with register targets at each of the four low-bit patterns.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_BEQ  = 3'd1,
    CLS_BNE  = 3'd2,
    CLS_JMP  = 3'd3,
    CLS_JAL  = 3'd4,
    CLS_JREG = 3'd5
  } pc_class_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/pcnu_branch.sv
module pcnu_branch #(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 16
) (
  input  logic [AW-1:0] seq_i,
  input  logic [OW-1:0] off_i,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic          want_eq_i,
  output logic          taken_o,
  output logic [AW-1:0] target_o
);
  localparam int unsigned EXT_W = AW - OW - 2;

  logic [AW-1:0] disp;
  logic          same;

  generate
    if (OW + 2 < AW) begin : g_sext
      assign disp = {{EXT_W{off_i[OW-1]}}, off_i, 2'b00};
    end else begin : g_trunc
      logic [OW+1:0] wide;
      assign wide = {off_i, 2'b00};
      assign disp = wide[AW-1:0];
    end
  endgenerate

  assign same     = (a_i == b_i);
  assign taken_o  = want_eq_i ? same : !same;
  assign target_o = seq_i + disp;
endmodule

// File: rtl/pcnu_jump.sv
module pcnu_jump #(
  parameter int unsigned AW = 32,
  parameter int unsigned JW = 26,
  parameter int unsigned RW = AW - JW - 2
) (
  input  logic [RW-1:0] region_i,
  input  logic [JW-1:0] field_i,
  output logic [AW-1:0] target_o
);
  assign target_o = {region_i, field_i, 2'b00};
endmodule

// File: rtl/pcnu_select.sv
module pcnu_select
  import pcnu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [2:0]    cls_i,
  input  logic          stall_i,
  input  logic [AW-1:0] seq_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_tgt_i,
  input  logic [AW-1:0] j_tgt_i,
  input  logic [AW-1:0] jreg_i,
  output logic          load_o,
  output logic [AW-1:0] next_o,
  output logic          fault_o,
  output logic          link_we_o
);
  logic          redirect;
  logic [AW-1:0] tgt;
  logic          misaligned;

  always_comb begin
    redirect = 1'b0;
    tgt      = seq_i;
    unique case (cls_i)
      CLS_BEQ, CLS_BNE: begin
        redirect = br_taken_i;
        tgt      = br_tgt_i;
      end
      CLS_JMP, CLS_JAL: begin
        redirect = 1'b1;
        tgt      = j_tgt_i;
      end
      CLS_JREG: begin
        redirect = 1'b1;
        tgt      = jreg_i;
      end
      default: begin
        redirect = 1'b0;
        tgt      = seq_i;
      end
    endcase
  end

  assign misaligned = redirect && (tgt[1:0] != 2'b00);
  assign fault_o    = !stall_i && misaligned;
  assign load_o     = !stall_i && !misaligned;
  assign next_o     = redirect ? tgt : seq_i;
  assign link_we_o  = !stall_i && !misaligned && (cls_i == CLS_JAL);
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned OW        = 16,
  parameter int unsigned JW        = 26,
  parameter int unsigned IW        = 5,
  parameter int unsigned LINK_REG  = 31,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall_i,
  input  logic [2:0]    cls_i,
  input  logic [OW-1:0] br_off_i,
  input  logic [JW-1:0] jfield_i,
  input  logic [AW-1:0] cmp_a_i,
  input  logic [AW-1:0] cmp_b_i,
  input  logic [AW-1:0] jreg_i,
  output logic [AW-1:0] pc_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_addr_o,
  output logic [IW-1:0] link_idx_o,
  output logic          fault_o
);
  localparam int unsigned RW = AW - JW - 2;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] seq;
  logic          br_taken;
  logic [AW-1:0] br_tgt;
  logic [AW-1:0] j_tgt;
  logic          load;
  logic [AW-1:0] next_pc;

  assign seq = pc_q + AW'(INSN_BYTES);

  pcnu_branch #(.AW(AW), .OW(OW)) u_branch (
    .seq_i     (seq),
    .off_i     (br_off_i),
    .a_i       (cmp_a_i),
    .b_i       (cmp_b_i),
    .want_eq_i (cls_i == CLS_BEQ),
    .taken_o   (br_taken),
    .target_o  (br_tgt)
  );

  pcnu_jump #(.AW(AW), .JW(JW), .RW(RW)) u_jump (
    .region_i (pc_q[AW-1 -: RW]),
    .field_i  (jfield_i),
    .target_o (j_tgt)
  );

  pcnu_select #(.AW(AW)) u_select (
    .cls_i      (cls_i),
    .stall_i    (stall_i),
    .seq_i      (seq),
    .br_taken_i (br_taken),
    .br_tgt_i   (br_tgt),
    .j_tgt_i    (j_tgt),
    .jreg_i     (jreg_i),
    .load_o     (load),
    .next_o     (next_pc),
    .fault_o    (fault_o),
    .link_we_o  (link_we_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_VEC[AW-1:0];
    end else if (load) begin
      pc_q <= next_pc;
    end
  end

  assign pc_o        = pc_q;
  assign link_addr_o = seq;
  assign link_idx_o  = IW'(LINK_REG);
endmodule

// File: rtl/pc_next_unit_sva.sv
module pc_next_unit_sva (
  input logic        clk,
  input logic        rst,
  input logic        stall_i,
  input logic [2:0]  cls_i,
  input logic [25:0] jfield_i,
  input logic [31:0] jreg_i,
  input logic [31:0] pc_o,
  input logic        link_we_o,
  input logic        fault_o
);
  p_reset_vec_r1: assert property (@(posedge clk)
    $past(rst) |-> pc_o == 32'h0);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && cls_i == 3'd0) |=> pc_o == $past(pc_o) + 32'd4);

  p_jump_field_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && cls_i == 3'd3) |=> pc_o[27:0] == {$past(jfield_i), 2'b00});

  p_link_target_r6: assert property (@(posedge clk) disable iff (rst)
    link_we_o |=> pc_o == {$past(pc_o[31:28]), $past(jfield_i), 2'b00});

  p_jreg_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && cls_i == 3'd5 && jreg_i[1:0] == 2'b00) |=> pc_o == $past(jreg_i));

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> pc_o == $past(pc_o));

  p_fault_nolink_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !link_we_o);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> pc_o == $past(pc_o));

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> !fault_o && !link_we_o);
endmodule

bind pc_next_unit pc_next_unit_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .stall_i   (stall_i),
  .cls_i     (cls_i),
  .jfield_i  (jfield_i),
  .jreg_i    (jreg_i),
  .pc_o      (pc_o),
  .link_we_o (link_we_o),
  .fault_o   (fault_o)
);

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        stall_i;
  logic [2:0]  cls_i;
  logic [15:0] br_off_i;
  logic [25:0] jfield_i;
  logic [31:0] cmp_a_i, cmp_b_i, jreg_i;
  logic [31:0] pc_o, link_addr_o;
  logic        link_we_o, fault_o;
  logic [4:0]  link_idx_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_pc;

  always #5 clk = ~clk;

  pc_next_unit u_pc_next_unit (
    .clk(clk), .rst(rst), .stall_i(stall_i), .cls_i(cls_i),
    .br_off_i(br_off_i), .jfield_i(jfield_i), .cmp_a_i(cmp_a_i),
    .cmp_b_i(cmp_b_i), .jreg_i(jreg_i), .pc_o(pc_o),
    .link_we_o(link_we_o), .link_addr_o(link_addr_o),
    .link_idx_o(link_idx_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic st, input logic [15:0] off,
                      input logic [25:0] jf, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] rt);
    logic        redir;
    logic [31:0] tgt, nxt, disp;
    logic        mis;
    @(negedge clk);
    cls_i = c; stall_i = st; br_off_i = off; jfield_i = jf;
    cmp_a_i = a; cmp_b_i = b; jreg_i = rt;
    #1;
    disp  = 32'($signed(off)) * 32'd4;
    redir = 1'b0;
    tgt   = exp_pc + 32'd4;
    case (c)
      3'd1: begin redir = (a == b); tgt = exp_pc + 32'd4 + disp; end // R3 R10
      3'd2: begin redir = (a != b); tgt = exp_pc + 32'd4 + disp; end // R4 R10
      3'd3, 3'd4: begin redir = 1'b1; tgt = (exp_pc & 32'hF000_0000) | (32'(jf) * 32'd4); end // R5 R6
      3'd5: begin redir = 1'b1; tgt = rt; end // R7
      default: redir = 1'b0; // R2
    endcase
    mis = redir && (tgt % 4 != 0);
    chk(st ? "R9 fault quiet" : "R8 fault flag", {31'd0, fault_o}, {31'd0, !st && mis});
    chk(st ? "R9 link quiet" : "R6 link write", {31'd0, link_we_o}, {31'd0, !st && !mis && c == 3'd4});
    if (c == 3'd4 && !st) begin
      chk("R6 link addr", link_addr_o, exp_pc + 32'd4);
      chk("R6 link idx", {27'd0, link_idx_o}, 32'd31);
    end
    if (st || mis) nxt = exp_pc;
    else if (redir) nxt = tgt;
    else nxt = exp_pc + 32'd4;
    @(posedge clk); #1;
    chk(st ? "R9 stall hold" : (mis ? "R8 hold" : "R2-R7 next pc"), pc_o, nxt);
    exp_pc = nxt;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] offs [5];
    logic [25:0] jfs  [3];
    logic [31:0] bases[4];
    offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'hFFFF;
    offs[3] = 16'h7FFF; offs[4] = 16'h8000;
    jfs[0] = 26'h0; jfs[1] = 26'h3FFFFFF; jfs[2] = 26'h1234567;
    bases[0] = 32'h0000_0000; bases[1] = 32'hA000_1000;
    bases[2] = 32'hFFFF_FFF0; bases[3] = 32'h7000_0040;
    rst = 1'b1; stall_i = 1'b0; cls_i = 3'd0; br_off_i = '0; jfield_i = '0;
    cmp_a_i = '0; cmp_b_i = '0; jreg_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vector", pc_o, 32'h0);
    @(negedge clk); rst = 1'b0;
    exp_pc = 32'h0;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++)
          for (int o = 0; o < 5; o++)
            for (int m = 0; m < 4; m++) begin
              step(3'd5, 1'b0, 16'h0, 26'h0, 0, 0, bases[(o + m + c) % 4]);
              step(3'(c), s[0], offs[o], jfs[(o + m) % 3], 32'h5A5A_0000 + 32'(m),
                   e[0] ? 32'h5A5A_0000 + 32'(m) : 32'h5A5A_8000, bases[m] + 32'(m));
            end
    // R10: backward branch wrapping below zero
    step(3'd5, 1'b0, 16'h0, 26'h0, 0, 0, 32'h0000_0008);
    step(3'd1, 1'b0, 16'hFFF0, 26'h0, 32'd7, 32'd7, 32'h0);
    chk("R10 wrap", exp_pc, 32'hFFFF_FFCC);
    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset mid-run", pc_o, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule